// File: doc/BRIEF.md
# Linked-Descriptor Transmit DMA Channel

This block is one transmit channel of a packet DMA engine. It follows a singly linked chain of buffer descriptors in a word-addressed memory. Each descriptor is four 32-bit words. For each descriptor the block streams the bytes of the referenced buffer out on a valid/ready byte interface. It then writes a status word back into the descriptor, which returns the descriptor to the host. The memory side is a single port with one outstanding transaction. A read is answered by a response strobe after any number of cycles. A write is taken in the cycle it is presented.

The host controls the channel through four small registers:
- a channel-enable bit;
- a head pointer, where writing a non-zero descriptor address starts the walk;
- a completion-acknowledge pointer;
- a self-clearing soft-reset bit.

Ownership passes back and forth through two flags in the descriptor's status word. The block clears the ownership flag when it finishes a descriptor. It sets an end-of-queue flag when the chain ends, so the host can see that the chain stopped and must start it again. An interrupt-pending output stays high until the host acknowledges the last completed descriptor. An error output reports a descriptor that the block found was not handed to it.

Top module: `txdesc_dma`

## Requirements
- R1: A descriptor at word address A holds, in order:
  - A+0: the next-descriptor pointer;
  - A+1: the buffer word address;
  - A+2: a buffer-length word, which is read but not used;
  - A+3: the mode/status word.

  All pointers are word addresses, and a next pointer of zero ends the chain.
- R2: Writing a non-zero value to the head register (register index 1) while the channel is idle makes the channel fetch and process the descriptor at that address. Reading index 1 returns the last accepted head value.
- R3: Bit 0 of the control register (index 0) enables the channel. While it is 0, an accepted head write is held and nothing is fetched or sent. Setting the bit starts the held request.
- R4: If the ownership flag (bit 29 of the mode/status word) is 0, the channel sends no bytes and does not modify the descriptor. It raises `err_flag` and stops. A later accepted head write clears `err_flag` and starts again.
- R5: The byte count is bits 10:0 of the mode/status word.
  - Bytes are sent in little-endian order within each buffer word: bits 7:0 first.
  - `tx_last` is high only on the final byte of the descriptor.
  - A count of zero sends nothing.
  - While `tx_ready` is low, `tx_valid`, `tx_data` and `tx_last` hold.
- R6: After the last byte, the channel writes the mode/status word back with bit 29 cleared and all other bits preserved. If the next pointer is non-zero, it continues with that descriptor.
- R7: When the finished descriptor's next pointer is zero, the write-back also sets bit 28 (end of queue) and the channel goes idle. A later head write restarts it.
- R8: `irq_pend` is high while the completion-acknowledge register (index 2) differs from the address of the most recently completed descriptor. Writing that address to index 2 clears `irq_pend`. Reading index 2 returns the written value.
- R9: Writing 1 to bit 0 of the soft-reset register (index 3) resets the channel. The bit reads back as 1 for SRST_CYCLES cycles, then as 0. The reset stops output and clears `err_flag`, `irq_pend`, the head register and the acknowledge register. The enable bit is kept.
- R10: `reg_rdata` is registered. It shows the register selected by `reg_addr` one cycle after the selection.
- R11: A head write made while the channel is busy is ignored. It neither changes the head register nor starts a later walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register index: 0 control, 1 head, 2 acknowledge, 3 soft reset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data of the selected register |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rvalid | input | 1 | Read response strobe |
| mem_rdata | input | 32 | Read response data |
| tx_valid | output | 1 | Output byte valid |
| tx_ready | input | 1 | Sink accepts byte |
| tx_data | output | 8 | Output byte |
| tx_last | output | 1 | Final byte of a descriptor |
| irq_pend | output | 1 | Completion not yet acknowledged |
| err_flag | output | 1 | Descriptor found without ownership |

## Verification
The bench builds the block with ADDR_W = 10 and SRST_CYCLES = 4. The 1024-word memory model then holds many descriptors and buffers. The soft-reset readback window is long enough to sample from the register port.

The memory model answers reads after a random delay of one to three cycles, and the sink drops `tx_ready` at random. Together they reach:
- stalls in the middle of a word;
- reads of the next descriptor directly after a write-back;
- byte counts of 1, 4, 5 and 0, which cover the word-boundary cases.

Random bits in the spare mode/status field show that the write-back leaves every other bit unchanged.

// File: rtl/txd_pkg.sv
package txd_pkg;
  localparam int OWN_BIT = 29;
  localparam int EOQ_BIT = 28;
  localparam int LEN_W   = 11;

  localparam logic [1:0] RA_CTRL = 2'd0;
  localparam logic [1:0] RA_HEAD = 2'd1;
  localparam logic [1:0] RA_ACK  = 2'd2;
  localparam logic [1:0] RA_SRST = 2'd3;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DREQ, ST_DWAIT, ST_CHECK, ST_BREQ, ST_BWAIT, ST_EMIT, ST_WB
  } eng_state_t;
endpackage

// File: rtl/txd_regs.sv
module txd_regs
  import txd_pkg::*;
#(
  parameter int SRST_CYCLES = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_wr,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  input  logic        eng_busy,
  output logic [31:0] reg_rdata,
  output logic        chan_en,
  output logic [31:0] head_ptr,
  output logic        head_go,
  output logic [31:0] ack_ptr,
  output logic        srst_busy
);
  localparam int CW = $clog2(SRST_CYCLES + 1);

  logic [CW-1:0] srst_cnt;

  assign srst_busy = (srst_cnt != '0);
  assign head_go   = reg_wr && (reg_addr == RA_HEAD) && !eng_busy && !srst_busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      chan_en   <= 1'b0;
      head_ptr  <= '0;
      ack_ptr   <= '0;
      srst_cnt  <= '0;
      reg_rdata <= '0;
    end else begin
      if (reg_wr && reg_addr == RA_SRST && reg_wdata[0]) begin
        srst_cnt <= CW'(SRST_CYCLES);
        head_ptr <= '0;
        ack_ptr  <= '0;
      end else begin
        if (srst_busy) srst_cnt <= srst_cnt - 1'b1;
        if (head_go) head_ptr <= reg_wdata;
        if (reg_wr && reg_addr == RA_ACK && !srst_busy) ack_ptr <= reg_wdata;
      end
      if (reg_wr && reg_addr == RA_CTRL) chan_en <= reg_wdata[0];
      case (reg_addr)
        RA_CTRL: reg_rdata <= {31'd0, chan_en};
        RA_HEAD: reg_rdata <= head_ptr;
        RA_ACK:  reg_rdata <= ack_ptr;
        default: reg_rdata <= {31'd0, srst_busy};
      endcase
    end
  end
endmodule

// File: rtl/txd_serial.sv
module txd_serial (
  input  logic        clk,
  input  logic        rst,
  input  logic        load,
  input  logic [31:0] word,
  input  logic [2:0]  nbytes,
  input  logic        last,
  input  logic        tx_ready,
  output logic        tx_valid,
  output logic [7:0]  tx_data,
  output logic        tx_last,
  output logic        empty
);
  logic [31:0] shreg;
  logic [2:0]  cnt;
  logic        last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg  <= '0;
      cnt    <= '0;
      last_q <= 1'b0;
    end else if (load) begin
      shreg  <= word;
      cnt    <= nbytes;
      last_q <= last;
    end else if (cnt != '0 && tx_ready) begin
      shreg <= {8'd0, shreg[31:8]};
      cnt   <= cnt - 1'b1;
    end
  end

  assign tx_valid = (cnt != '0);
  assign tx_data  = shreg[7:0];
  assign tx_last  = last_q && (cnt == 3'd1);
  assign empty    = (cnt == '0);
endmodule

// File: rtl/txd_engine.sv
module txd_engine
  import txd_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              chan_en,
  input  logic              head_go,
  input  logic [31:0]       head_ptr,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_rvalid,
  input  logic [31:0]       mem_rdata,
  output logic              ser_load,
  output logic [2:0]        ser_nbytes,
  output logic              ser_last,
  input  logic              ser_empty,
  output logic              busy,
  output logic              err,
  output logic [31:0]       done_ptr
);
  eng_state_t        state;
  logic              pend;
  logic [31:0]       cur;
  logic [1:0]        widx;
  logic [LEN_W-1:0]  rem;
  logic [ADDR_W-1:0] bptr;
  logic [31:0]       dw [4];
  logic [31:0]       wb_word;
  logic              chain_end;

  assign busy       = (state != ST_IDLE);
  assign chain_end  = (dw[0] == 32'd0);
  assign wb_word    = (dw[3] & ~(32'd1 << OWN_BIT)) | (chain_end ? (32'd1 << EOQ_BIT) : 32'd0);
  assign ser_load   = (state == ST_BWAIT) && mem_rvalid;
  assign ser_nbytes = (rem > LEN_W'(4)) ? 3'd4 : rem[2:0];
  assign ser_last   = (rem <= LEN_W'(4));

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      pend      <= 1'b0;
      cur       <= '0;
      widx      <= '0;
      rem       <= '0;
      bptr      <= '0;
      err       <= 1'b0;
      done_ptr  <= '0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      for (int i = 0; i < 4; i++) dw[i] <= '0;
    end else begin
      mem_req <= 1'b0;
      mem_we  <= 1'b0;
      case (state)
        ST_IDLE: if (pend && chan_en && head_ptr != 32'd0) begin
          pend  <= 1'b0;
          err   <= 1'b0;
          cur   <= head_ptr;
          widx  <= '0;
          state <= ST_DREQ;
        end
        ST_DREQ: begin
          mem_req  <= 1'b1;
          mem_addr <= cur[ADDR_W-1:0] + ADDR_W'(widx);
          state    <= ST_DWAIT;
        end
        ST_DWAIT: if (mem_rvalid) begin
          dw[widx] <= mem_rdata;
          if (widx == 2'd3) state <= ST_CHECK;
          else begin
            widx  <= widx + 1'b1;
            state <= ST_DREQ;
          end
        end
        ST_CHECK: if (!dw[3][OWN_BIT]) begin
          err   <= 1'b1;
          state <= ST_IDLE;
        end else begin
          rem   <= dw[3][LEN_W-1:0];
          bptr  <= dw[1][ADDR_W-1:0];
          state <= (dw[3][LEN_W-1:0] == '0) ? ST_WB : ST_BREQ;
        end
        ST_BREQ: begin
          mem_req  <= 1'b1;
          mem_addr <= bptr;
          state    <= ST_BWAIT;
        end
        ST_BWAIT: if (mem_rvalid) begin
          rem   <= rem - LEN_W'(ser_nbytes);
          bptr  <= bptr + 1'b1;
          state <= ST_EMIT;
        end
        ST_EMIT: if (ser_empty) state <= (rem == '0) ? ST_WB : ST_BREQ;
        ST_WB: begin
          mem_req   <= 1'b1;
          mem_we    <= 1'b1;
          mem_addr  <= cur[ADDR_W-1:0] + ADDR_W'(3);
          mem_wdata <= wb_word;
          done_ptr  <= cur;
          if (chain_end) state <= ST_IDLE;
          else begin
            cur   <= dw[0];
            widx  <= '0;
            state <= ST_DREQ;
          end
        end
        default: state <= ST_IDLE;
      endcase
      if (head_go) pend <= 1'b1;
    end
  end
endmodule

// File: rtl/txdesc_dma.sv
module txdesc_dma
  import txd_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int SRST_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_rvalid,
  input  logic [31:0]       mem_rdata,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_data,
  output logic              tx_last,
  output logic              irq_pend,
  output logic              err_flag
);
  logic        chan_en, head_go, srst_busy, eng_busy, chan_rst;
  logic [31:0] head_ptr, ack_ptr, done_ptr;
  logic        ser_load, ser_last, ser_empty;
  logic [2:0]  ser_nbytes;

  assign chan_rst = rst || srst_busy;

  txd_regs #(.SRST_CYCLES(SRST_CYCLES)) u_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .eng_busy(eng_busy), .reg_rdata(reg_rdata),
    .chan_en(chan_en), .head_ptr(head_ptr), .head_go(head_go),
    .ack_ptr(ack_ptr), .srst_busy(srst_busy)
  );

  txd_engine #(.ADDR_W(ADDR_W)) u_engine (
    .clk(clk), .rst(chan_rst), .chan_en(chan_en), .head_go(head_go),
    .head_ptr(head_ptr), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .ser_load(ser_load), .ser_nbytes(ser_nbytes),
    .ser_last(ser_last), .ser_empty(ser_empty), .busy(eng_busy),
    .err(err_flag), .done_ptr(done_ptr)
  );

  txd_serial u_serial (
    .clk(clk), .rst(chan_rst), .load(ser_load), .word(mem_rdata),
    .nbytes(ser_nbytes), .last(ser_last), .tx_ready(tx_ready),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
    .empty(ser_empty)
  );

  always_ff @(posedge clk) begin
    if (chan_rst) irq_pend <= 1'b0;
    else          irq_pend <= (ack_ptr != done_ptr);
  end
endmodule

// File: rtl/txdesc_dma_chk.sv
module txdesc_dma_chk (
  input logic        clk,
  input logic        rst,
  input logic        reg_wr,
  input logic [1:0]  reg_addr,
  input logic [31:0] reg_wdata,
  input logic        mem_req,
  input logic        mem_we,
  input logic [31:0] mem_wdata,
  input logic        tx_valid,
  input logic        tx_ready,
  input logic [7:0]  tx_data,
  input logic        tx_last,
  input logic        irq_pend,
  input logic        err_flag
);
  // R5: a stalled byte holds (soft reset is only issued while no stream runs)
  assert_hold_stalled_R5: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

  // R4: the error stop never coincides with output
  assert_err_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    err_flag |-> !tx_valid);

  // R6: each write-back returns ownership and happens after the stream drained
  assert_wb_release_R6: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> (!mem_wdata[29] && !tx_valid));

  // R9: soft reset silences output and flags
  assert_srst_clear_R9: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_addr == 2'd3 && reg_wdata[0]) |=> ##1 (!tx_valid && !err_flag && !irq_pend));
endmodule

bind txdesc_dma txdesc_dma_chk u_chk (.*);

// File: tb/txdesc_dma_bench.sv
module txdesc_dma_bench;
  localparam int AW  = 10;
  localparam int SRC = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = 32'd0;
  logic        tx_valid, tx_last, irq_pend, err_flag;
  logic        tx_ready = 1'b1;
  logic [7:0]  tx_data;

  txdesc_dma #(.ADDR_W(AW), .SRST_CYCLES(SRC)) u_txdesc_dma (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .tx_last(tx_last),
    .irq_pend(irq_pend), .err_flag(err_flag)
  );

  // memory model: random read latency, writes taken at once
  logic [31:0]   mem_m [0:1023];
  logic [31:0]   orig  [0:1023];
  logic          bw_en = 1'b0;
  logic [AW-1:0] bw_addr = '0;
  logic [31:0]   bw_data = 32'd0;
  logic          rpend = 1'b0;
  int            rlat = 0;
  logic [AW-1:0] raddr = '0;

  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    if (bw_en) mem_m[bw_addr] <= bw_data;
    if (mem_req && mem_we) mem_m[mem_addr] <= mem_wdata;
    if (mem_req && !mem_we) begin
      rpend <= 1'b1;
      raddr <= mem_addr;
      rlat  <= int'($urandom_range(0, 2));
    end else if (rpend) begin
      if (rlat == 0) begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= mem_m[raddr];
        rpend      <= 1'b0;
      end else rlat <= rlat - 1;
    end
  end

  logic rdy_rand = 1'b0;
  always @(negedge clk) tx_ready <= rdy_rand ? ($urandom_range(0, 3) != 0) : 1'b1;

  logic [7:0] cap_d[$];
  logic       cap_l[$];
  logic [7:0] exp_d[$];
  logic       exp_l[$];

  always @(posedge clk) begin
    if (!rst && tx_valid && tx_ready) begin
      cap_d.push_back(tx_data);
      cap_l.push_back(tx_last);
    end
  end

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic poke(input int a, input logic [31:0] d);
    @(negedge clk);
    bw_en = 1'b1; bw_addr = AW'(a); bw_data = d;
    @(negedge clk);
    bw_en = 1'b0;
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    @(negedge clk);
    d = reg_rdata;
  endtask

  // descriptor with random payload; expected bytes follow the little-endian rule of R5
  task automatic build(input int da, input int nxt, input int ba, input int len,
                       input bit own, input bit expect_out);
    logic [31:0] w, m;
    logic [7:0]  v;
    int nw;
    nw = (len + 3) / 4;
    for (int k = 0; k < nw; k++) begin
      w = 32'd0;
      for (int b = 0; b < 4; b++) begin
        v = 8'($urandom);
        w[8*b +: 8] = v;
        if (expect_out && (4*k + b) < len) begin
          exp_d.push_back(v);
          exp_l.push_back((4*k + b) == len - 1);
        end
      end
      poke(ba + k, w);
    end
    m = 32'hC000_0000 | (own ? 32'h2000_0000 : 32'd0) | ($urandom & 32'h0FFF_F800) | 32'(len);
    poke(da, 32'(nxt));
    poke(da + 1, 32'(ba));
    poke(da + 2, 32'(len));
    poke(da + 3, m);
    orig[da] = m;
  endtask

  task automatic check_stream(input string tag);
    int bad;
    bit ok;
    bad = -1;
    ok = (cap_d.size() == exp_d.size());
    check(ok, {tag, " byte count"}, 32'(cap_d.size()), 32'(exp_d.size()));
    if (ok) begin
      for (int i = 0; i < cap_d.size(); i++)
        if (bad < 0 && (cap_d[i] !== exp_d[i] || cap_l[i] !== exp_l[i])) bad = i;
      check(bad < 0, {tag, " byte/last order"},
            (bad < 0) ? 32'd0 : {23'd0, cap_l[bad], cap_d[bad]},
            (bad < 0) ? 32'd0 : {23'd0, exp_l[bad], exp_d[bad]});
    end
    cap_d.delete(); cap_l.delete(); exp_d.delete(); exp_l.delete();
  endtask

  task automatic check_mode(input int da, input int nxt, input string tag);
    logic [31:0] e;
    e = (orig[da] & ~32'h2000_0000) | ((nxt == 0) ? 32'h1000_0000 : 32'd0);
    check(mem_m[da + 3] === e, tag, mem_m[da + 3], e);
  endtask

  task automatic wait_done(input int da);
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if (!mem_m[da + 3][29]) break;
    end
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    int nd, da, ba, ln, last_da;
    void'($urandom(32'd2024));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // reset state
    check(!tx_valid && !irq_pend && !err_flag, "R9 reset outputs quiet",
          {29'd0, tx_valid, irq_pend, err_flag}, 32'd0);
    reg_read(2'd0, rd);
    check(rd == 32'd0, "R10 control reads 0 after reset", rd, 32'd0);
    reg_read(2'd1, rd);
    check(rd == 32'd0, "R10 head reads 0 after reset", rd, 32'd0);

    // R3: head accepted while disabled, nothing happens until enable
    build(16, 0, 700, 5, 1'b1, 1'b1);
    reg_write(2'd1, 32'd16);
    repeat (40) @(negedge clk);
    check(cap_d.size() == 0, "R3 no bytes while disabled", 32'(cap_d.size()), 32'd0);
    check(mem_m[19][29] == 1'b1, "R3 descriptor untouched while disabled", mem_m[19], orig[16]);
    reg_write(2'd0, 32'd1);
    wait_done(16);
    check_stream("R5 single descriptor len 5");
    check_mode(16, 0, "R7 end-of-queue write-back");
    reg_read(2'd1, rd);
    check(rd == 32'd16, "R2 head readback", rd, 32'd16);
    reg_read(2'd0, rd);
    check(rd == 32'd1, "R10 control readback", rd, 32'd1);
    check(irq_pend == 1'b1, "R8 pending after completion", {31'd0, irq_pend}, 32'd1);
    reg_write(2'd2, 32'd16);
    repeat (3) @(negedge clk);
    check(irq_pend == 1'b0, "R8 cleared by acknowledge", {31'd0, irq_pend}, 32'd0);
    reg_read(2'd2, rd);
    check(rd == 32'd16, "R8 acknowledge readback", rd, 32'd16);

    // R1/R6/R11: chain of lengths 1,4,5 with stalls, head write while busy ignored
    rdy_rand = 1'b1;
    build(32, 36, 710, 1, 1'b1, 1'b1);
    build(36, 40, 720, 4, 1'b1, 1'b1);
    build(40, 0, 730, 5, 1'b1, 1'b1);
    build(60, 0, 740, 7, 1'b1, 1'b0);
    reg_write(2'd1, 32'd32);
    repeat (2) @(negedge clk);
    reg_write(2'd1, 32'd60);
    wait_done(40);
    repeat (30) @(negedge clk);
    check_stream("R1 R5 chain 1/4/5 with stalls");
    check_mode(32, 36, "R6 first write-back keeps bits");
    check_mode(36, 40, "R6 middle write-back");
    check_mode(40, 0, "R7 tail sets end-of-queue");
    check(mem_m[63] === orig[60], "R11 busy head write ignored", mem_m[63], orig[60]);
    reg_read(2'd1, rd);
    check(rd == 32'd32, "R11 head register unchanged", rd, 32'd32);

    // R4: unowned descriptor
    rdy_rand = 1'b0;
    build(70, 0, 750, 6, 1'b0, 1'b0);
    reg_write(2'd1, 32'd70);
    repeat (60) @(negedge clk);
    check(err_flag == 1'b1, "R4 error flag raised", {31'd0, err_flag}, 32'd1);
    check(cap_d.size() == 0, "R4 no bytes sent", 32'(cap_d.size()), 32'd0);
    check(mem_m[73] === orig[70], "R4 descriptor not modified", mem_m[73], orig[70]);

    // R7 restart, clears error
    build(80, 0, 760, 3, 1'b1, 1'b1);
    reg_write(2'd1, 32'd80);
    wait_done(80);
    check(err_flag == 1'b0, "R4 restart clears error", {31'd0, err_flag}, 32'd0);
    check_stream("R7 restart after stop");
    check_mode(80, 0, "R7 restart write-back");

    // R5 zero length
    build(90, 0, 770, 0, 1'b1, 1'b0);
    reg_write(2'd1, 32'd90);
    wait_done(90);
    check(cap_d.size() == 0, "R5 zero length sends nothing", 32'(cap_d.size()), 32'd0);
    check_mode(90, 0, "R6 zero length still released");

    // R9 soft reset with error and pending set
    build(96, 0, 780, 2, 1'b0, 1'b0);
    reg_write(2'd1, 32'd96);
    repeat (60) @(negedge clk);
    check(err_flag && irq_pend, "R9 precondition error and pending",
          {30'd0, err_flag, irq_pend}, 32'd3);
    reg_write(2'd3, 32'd1);
    reg_read(2'd3, rd);
    check(rd == 32'd1, "R9 soft reset reads busy", rd, 32'd1);
    repeat (10) @(negedge clk);
    reg_read(2'd3, rd);
    check(rd == 32'd0, "R9 soft reset self-clears", rd, 32'd0);
    check(!err_flag && !irq_pend, "R9 flags cleared", {30'd0, err_flag, irq_pend}, 32'd0);
    reg_read(2'd1, rd);
    check(rd == 32'd0, "R9 head cleared", rd, 32'd0);
    reg_read(2'd0, rd);
    check(rd == 32'd1, "R9 enable kept", rd, 32'd1);

    // random chains
    rdy_rand = 1'b1;
    for (int it = 0; it < 8; it++) begin
      nd = int'($urandom_range(1, 3));
      last_da = 0;
      for (int d = 0; d < nd; d++) begin
        da = 200 + it * 16 + d * 4;
        ba = 400 + (it * 3 + d) * 12;
        ln = int'($urandom_range(1, 40));
        build(da, (d == nd - 1) ? 0 : da + 4, ba, ln, 1'b1, 1'b1);
        last_da = da;
      end
      reg_write(2'd1, 32'(200 + it * 16));
      wait_done(last_da);
      check_stream("R5 random chain");
      for (int d = 0; d < nd; d++) begin
        da = 200 + it * 16 + d * 4;
        check_mode(da, (d == nd - 1) ? 0 : da + 4, "R6 R7 random write-back");
      end
      check(irq_pend == 1'b1, "R8 random pending", {31'd0, irq_pend}, 32'd1);
      reg_write(2'd2, 32'(last_da));
      repeat (3) @(negedge clk);
      check(irq_pend == 1'b0, "R8 random acknowledge", {31'd0, irq_pend}, 32'd0);
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule